// File: doc/BRIEF.md
# Pulse Accumulator with Mode Control

This block tallies activity on one external pulse line into an 8-bit counter. It has two ways of counting. In event mode it adds one for every chosen transition of the line. In gated-time mode it adds one every 64 system clocks, but only while the line is not at its blocking level. The line always passes through a two-flop synchronizer before any edge or level is judged.

A byte-wide control register turns the block on and off and selects the mode. It also holds a polarity bit, whose meaning depends on the mode. Two further fields in that register (a capture/compare channel select and a 2-bit periodic rate) are only stored and returned on read. They have no effect inside this block.

A small register bus, with a 2-bit address and a write strobe, gives access to the control register, the counter and a status register. Reads are combinational. When the counter wraps it raises a sticky overflow flag, which software clears by writing 1 to it.

Top module: `pulse_tally`

## Requirements
- R1: After reset, the control register (address 0), the counter (address 1) and the status register (address 2) all read 0x00, and `ovf_flag` is 0.
- R2: The control byte has these fields: bit 6 enable, bit 5 mode (0 = event, 1 = gated), bit 4 polarity, bit 2 channel select, bits 1:0 rate. Bits 7 and 3 always read 0. Channel select and rate read back exactly as written and have no effect on counting.
- R3: While enable is 0, the counter does not change except through a bus write to address 1.
- R4: In event mode with polarity 0, each falling edge of `pulse_in` adds one to the counter, and rising edges add nothing.
- R5: In event mode with polarity 1, each rising edge of `pulse_in` adds one, and falling edges add nothing.
- R6: In gated mode with polarity 0, the counter adds one every 64 clocks while `pulse_in` is high, and a low input blocks counting.
- R7: In gated mode with polarity 1, a high input blocks counting, and the counter adds one every 64 clocks while `pulse_in` is low.
- R8: The divide-by-64 prescaler is held at zero while enable is 0. After enable is written to 1, the first gated increment comes 64 clocks later.
- R9: When the counter wraps from 0xFF to 0x00, the overflow flag (status bit 0 and `ovf_flag`) is set and stays set. Writing 1 to status bit 0 clears it. If a wrap and a clear fall in the same cycle, the flag stays set.
- R10: A bus write to address 1 loads the counter. It wins over an increment in the same cycle, and that increment then does not set the overflow flag.
- R11: A transition on `pulse_in` that is applied before rising clock edge k changes the counter at rising edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | External pulse line, asynchronous |
| bus_addr | input | 2 | Register select: 0 control, 1 counter, 2 status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
If the synchronizer or edge detector is wrong, the counter reads back off by one: either after a single pulse, or because it changes one edge earlier or later than the three-edge latency. If the gate polarity or the mode decode is wrong, the counter moves when it should stay still, and this shows within one prescaler period of 64 clocks. If the prescaler is not cleared while disabled, a disable and re-enable sequence produces an early tick, and the counter shows it before 64 clocks have passed since enable. If the overflow flag or the write priority is wrong, the status register shows it one clock after the wrap or the clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int PRESC_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

    localparam int B_EN    = 6;
    localparam int B_MODE  = 5;
    localparam int B_POL   = 4;
    localparam int B_CHSEL = 2;

    typedef struct packed {
        logic       en;
        logic       mode;
        logic       pol;
        logic       chsel;
        logic [1:0] rate;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[B_EN]    = c.en;
        b[B_MODE]  = c.mode;
        b[B_POL]   = c.pol;
        b[B_CHSEL] = c.chsel;
        b[1:0]     = c.rate;
        return b;
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] b);
        ctrl_t c;
        c.en    = b[B_EN];
        c.mode  = b[B_MODE];
        c.pol   = b[B_POL];
        c.chsel = b[B_CHSEL];
        c.rate  = b[1:0];
        return c;
    endfunction
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d  = {sh_q[SH_W-2:0], din};
        level = sh_q[STAGES-1];
        rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
    parameter int WIDTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + 1'b1 : '0;
        tick  = run && (cnt_q == {WIDTH{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally
    import pa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ovf_flag
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] cnt;
        logic              ovf;
    } state_t;

    state_t st_d, st_q;

    logic lvl, rise, fall, tick;
    logic inc, wr_ctrl, wr_cnt, clr_ovf;
    logic ctrl_en;
    logic [DATA_W-1:0] cnt_val;

    pa_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(pulse_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    pa_prescaler #(.WIDTH(PRESC_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .run(st_q.ctrl.en), .tick(tick)
    );

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_cnt  = bus_wr && (bus_addr == A_CNT);
        clr_ovf = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

        inc = 1'b0;
        if (st_q.ctrl.en) begin
            if (!st_q.ctrl.mode) inc = st_q.ctrl.pol ? rise : fall;
            else                 inc = tick && (lvl != st_q.ctrl.pol);
        end

        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = ctrl_unpack(bus_wdata);

        if (wr_cnt)   st_d.cnt = bus_wdata;
        else if (inc) st_d.cnt = st_q.cnt + 1'b1;

        if (clr_ovf) st_d.ovf = 1'b0;
        if (inc && !wr_cnt && (st_q.cnt == {DATA_W{1'b1}})) st_d.ovf = 1'b1;

        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_pack(st_q.ctrl);
            A_CNT:   bus_rdata = st_q.cnt;
            A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, st_q.ovf};
            default: bus_rdata = '0;
        endcase

        ovf_flag = st_q.ovf;
        ctrl_en  = st_q.ctrl.en;
        cnt_val  = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

module pulse_tally_chk
    import pa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ovf_flag,
    input logic              ctrl_en,
    input logic [DATA_W-1:0] cnt_val
);
    logic cnt_w, clr_w;
    assign cnt_w = bus_wr && (bus_addr == A_CNT);
    assign clr_w = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[3] == 1'b0));

    a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !cnt_w) |=> $stable(cnt_val));

    a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w |=> (cnt_val == $past(bus_wdata)));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_w) |=> ovf_flag);

    a_r9_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val == 8'hFF && !cnt_w) |=> (cnt_val != 8'h00 || ovf_flag));

    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_w |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 8'd1));
endmodule

bind pulse_tally pulse_tally_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag),
    .ctrl_en(ctrl_en), .cnt_val(cnt_val)
);

// File: tb/test_pulse_tally.sv
module test_pulse_tally;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_in = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ovf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // control encodings: en=0x40, mode=0x20, pol=0x10, chsel=0x04, rate=0x03
    localparam logic [7:0] EV_FALL = 8'h40;
    localparam logic [7:0] EV_RISE = 8'h50;
    localparam logic [7:0] GT_LOW  = 8'h60;
    localparam logic [7:0] GT_HIGH = 8'h70;

    always #10 clk = ~clk;

    pulse_tally i_pulse_tally (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ovf_flag(ovf_flag)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        pulse_in = v;
        cycles(4);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 count", v, 8'h00);
        rd(2'd2, v); check("R1 status", v, 8'h00);
        check("R1 ovf_flag", {7'd0, ovf_flag}, 8'h00);
    endtask

    task automatic t_ctrl_layout;
        logic [7:0] v;
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 reserved bits", v, 8'h77);
        wr(2'd0, 8'h06); rd(2'd0, v); check("R2 chsel/rate readback", v, 8'h06);
        wr(2'd1, 8'h00);
        wr(2'd0, EV_RISE | 8'h07);
        set_pin(1'b1); set_pin(1'b0);
        rd(2'd1, v); check("R2 chsel/rate no effect on counting", v, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h10);
        for (int i = 0; i < 3; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd(2'd1, v); check("R3 event disabled", v, 8'h10);
        wr(2'd0, 8'h20); pulse_in = 1'b1; cycles(150);
        rd(2'd1, v); check("R3 gated disabled", v, 8'h10);
        pulse_in = 1'b0; cycles(4);
    endtask

    task automatic t_event_fall;
        logic [7:0] v;
        wr(2'd1, 8'h00); wr(2'd0, EV_FALL);
        set_pin(1'b1); rd(2'd1, v); check("R4 rise ignored", v, 8'h00);
        set_pin(1'b0); rd(2'd1, v); check("R4 fall counted", v, 8'h01);
        for (int i = 0; i < 4; i++) begin set_pin(1'b1); set_pin(1'b0); end
        rd(2'd1, v); check("R4 five falls", v, 8'h05);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_event_rise;
        logic [7:0] v;
        wr(2'd1, 8'h00); wr(2'd0, EV_RISE);
        set_pin(1'b1); rd(2'd1, v); check("R5 rise counted", v, 8'h01);
        set_pin(1'b0); rd(2'd1, v); check("R5 fall ignored", v, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_gated_low;
        logic [7:0] v;
        pulse_in = 1'b1; cycles(4);
        wr(2'd1, 8'h00);
        // enable lands on the write edge; increments at +64, +128, +192
        wr(2'd0, GT_LOW); cycles(199);
        rd(2'd1, v); check("R6 high counts every 64", v, 8'h03);
        pulse_in = 1'b0; cycles(200);
        rd(2'd1, v); check("R6 low blocks", v, 8'h03);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_gated_high;
        logic [7:0] v;
        pulse_in = 1'b1; cycles(4);
        wr(2'd1, 8'h00);
        wr(2'd0, GT_HIGH); cycles(200);
        rd(2'd1, v); check("R7 high blocks", v, 8'h00);
        pulse_in = 1'b0; cycles(130);
        rd(2'd1, v); check("R7 low counts", v, 8'h02);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_presc_reset;
        logic [7:0] v;
        pulse_in = 1'b1; cycles(4);
        wr(2'd1, 8'h00);
        wr(2'd0, GT_LOW); cycles(40);
        wr(2'd0, 8'h00); cycles(5);
        wr(2'd0, GT_LOW); cycles(40);
        rd(2'd1, v); check("R8 prescaler cleared while disabled", v, 8'h00);
        cycles(30);
        rd(2'd1, v); check("R8 first tick after 64", v, 8'h01);
        wr(2'd0, 8'h00);
        pulse_in = 1'b0; cycles(4);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd1, 8'hFE); wr(2'd0, EV_RISE);
        set_pin(1'b1); set_pin(1'b0);
        rd(2'd2, v); check("R9 no flag at 0xFF", v, 8'h00);
        set_pin(1'b1); set_pin(1'b0);
        rd(2'd1, v); check("R9 wrapped count", v, 8'h00);
        rd(2'd2, v); check("R9 flag set", v, 8'h01);
        wr(2'd2, 8'h00); rd(2'd2, v); check("R9 write 0 keeps flag", v, 8'h01);
        wr(2'd2, 8'h01); rd(2'd2, v); check("R9 write 1 clears", v, 8'h00);
        // set and clear in the same cycle: set wins
        wr(2'd1, 8'hFF);
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 2'd2; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(2'd2, v); check("R9 set wins over clear", v, 8'h01);
        check("R9 ovf_flag port", {7'd0, ovf_flag}, 8'h01);
        wr(2'd2, 8'h01);
        set_pin(1'b0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_write_prio;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd1, 8'hFF); wr(2'd0, EV_RISE);
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = 2'd1; bus_wdata = 8'h42; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(2'd1, v); check("R10 write beats increment", v, 8'h42);
        rd(2'd2, v); check("R10 no overflow on overridden wrap", v, 8'h00);
        set_pin(1'b0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_latency;
        logic [7:0] v;
        wr(2'd1, 8'h00); wr(2'd0, EV_RISE);
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk); bus_addr = 2'd1;
        @(negedge clk); #1 check("R11 unchanged after 2 edges", bus_rdata, 8'h00);
        @(negedge clk); #1 check("R11 changed at 3rd edge", bus_rdata, 8'h01);
        set_pin(1'b0);
        rd(2'd1, v); check("R11 single count", v, 8'h01);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_ctrl_layout();
        t_disabled();
        t_event_fall();
        t_event_rise();
        t_gated_low();
        t_gated_high();
        t_presc_reset();
        t_overflow();
        t_write_prio();
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule